// File: doc/BRIEF.md
# Integer ALU with Leading-Bit Counters

This block is the combinational integer datapath of a single-issue RISC-style core. From two 32-bit operands, a separate 5-bit immediate shift amount and a 5-bit operation code, it produces a 32-bit result, an overflow flag and a write-enable for the destination register in the same cycle. It has no state. The surrounding pipeline samples the outputs at its own stage boundary.

The operations are:
- add and subtract, each in a wrapping form and a form that flags signed overflow;
- the four bitwise operations;
- left, logical-right and arithmetic-right shifts, by an immediate amount or by an amount taken from a register;
- counting of leading zeros and of leading ones;
- ten set-on-condition tests, each returning 0 or 1.

When an overflow is flagged the sum is still presented, but the write-enable drops so that the destination keeps its old value. The exception itself is raised by logic outside this block.

Top module: `int_alu`

## Requirements
- R1: Codes 0 (add, wrapping) and 2 (subtract, wrapping) return A+B and A−B modulo 2^32 and never raise `ovf_o`.
- R2: Code 1 (add, trapping) returns A+B modulo 2^32 and raises `ovf_o` exactly when the signed sum lies outside the signed 32-bit range.
- R3: Code 3 (subtract, trapping) returns A−B modulo 2^32 and raises `ovf_o` exactly when the signed difference lies outside the signed 32-bit range.
- R4: Codes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT(A OR B), all bitwise.
- R5: Codes 8, 9 and 10 shift B by `shamt_i`: 8 shifts left with zero fill, 9 shifts right with zero fill, and 10 shifts right while copying bit 31 into the vacated bits.
- R6: Codes 11, 12 and 13 perform the same three shifts on B by the amount A[4:0]. Bits A[31:5] have no effect.
- R7: Code 14 returns the count of zero bits above the most significant one in A, and returns 32 when A is zero.
- R8: Code 15 returns the count of consecutive one bits in A starting at bit 31, and returns 32 when A is all ones.
- R9: Codes 16 to 21 return 1 when the test holds and 0 otherwise. The tests, in code order, are A==B, A!=B, signed A>=B, unsigned A>=B, signed A<B and unsigned A<B.
- R10: Codes 22 to 25 return 1 when signed A is, in code order, >=0, >0, <=0 or <0, and 0 otherwise. B has no effect.
- R11: Codes 26 to 31 return zero with `ovf_o` low and `wr_en_o` high.
- R12: `wr_en_o` is low exactly when `ovf_o` is high, for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 32 | Operand A (also the variable shift amount and the count/zero-test source) |
| b_i | input | 32 | Operand B (the shifted value) |
| shamt_i | input | 5 | Immediate shift amount |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow on a trapping add or subtract |
| wr_en_o | output | 1 | Destination write permitted |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle as the stimulus that provokes it. An error in the overflow or leading-count logic, however, appears only for a narrow set of operand values. The bench therefore drives the sign-boundary sums, the all-zero and all-one inputs and every shift amount from 0 to 31 as directed cases, alongside random operands. It checks each vector against its reference model on the following clock phase. Stray high bits in A[31:5] and in B are driven during variable shifts and zero tests, so that a wrong operand tap gives a wrong result.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADDW = 5'd0,  OP_ADDT = 5'd1,  OP_SUBW = 5'd2,  OP_SUBT = 5'd3,
        OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_NOR  = 5'd7,
        OP_SLLI = 5'd8,  OP_SRLI = 5'd9,  OP_SRAI = 5'd10,
        OP_SLLV = 5'd11, OP_SRLV = 5'd12, OP_SRAV = 5'd13,
        OP_CLZ  = 5'd14, OP_CLO  = 5'd15,
        OP_EQ   = 5'd16, OP_NE   = 5'd17, OP_GES  = 5'd18, OP_GEU  = 5'd19,
        OP_LTS  = 5'd20, OP_LTU  = 5'd21,
        OP_GEZ  = 5'd22, OP_GTZ  = 5'd23, OP_LEZ  = 5'd24, OP_LTZ  = 5'd25
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_e;

    localparam int unsigned FIRST_CMP = 16;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         sovf_o
);
    logic [W-1:0] b_eff;
    logic         same_in_sign;

    always_comb begin
        b_eff        = sub_i ? ~b_i : b_i;
        sum_o        = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
        // add: operands agree in sign; sub: operands disagree
        same_in_sign = (a_i[W-1] == b_eff[W-1]);
        sovf_o       = same_in_sign && (sum_o[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import int_alu_pkg::*;
#(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  val_i,
    input  logic [SW-1:0] amt_i,
    input  shift_kind_e   kind_i,
    output logic [W-1:0]  res_o
);
    always_comb begin
        unique case (kind_i)
            SH_LEFT: res_o = val_i << amt_i;
            SH_RLOG: res_o = val_i >> amt_i;
            SH_RARI: res_o = W'($signed(val_i) >>> amt_i);
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_lead_count.sv
module alu_lead_count #(
    parameter int W     = 32,
    parameter bit ONES  = 1'b0,
    localparam int CW   = $clog2(W) + 1
) (
    input  logic [W-1:0]  val_i,
    output logic [CW-1:0] cnt_o
);
    logic [W-1:0] scan;

    generate
        if (ONES) begin : g_ones
            assign scan = ~val_i;
        end else begin : g_zeros
            assign scan = val_i;
        end
    endgenerate

    always_comb begin
        logic found;
        found = 1'b0;
        cnt_o = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && scan[i]) begin
                found = 1'b1;
                cnt_o = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   sel_i,
    output logic         hit_o
);
    logic eq, lt_s, lt_u, a_neg, a_zero;

    always_comb begin
        eq     = (a_i == b_i);
        lt_u   = (a_i < b_i);
        lt_s   = ($signed(a_i) < $signed(b_i));
        a_neg  = a_i[W-1];
        a_zero = (a_i == '0);
        unique case (sel_i)
            4'd0:    hit_o = eq;
            4'd1:    hit_o = !eq;
            4'd2:    hit_o = !lt_s;
            4'd3:    hit_o = !lt_u;
            4'd4:    hit_o = lt_s;
            4'd5:    hit_o = lt_u;
            4'd6:    hit_o = !a_neg;
            4'd7:    hit_o = !a_neg && !a_zero;
            4'd8:    hit_o = a_neg || a_zero;
            4'd9:    hit_o = a_neg;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int W  = 32,
    localparam int SW = $clog2(W),
    localparam int CW = SW + 1
) (
    input  logic [4:0]    op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic [SW-1:0] shamt_i,
    output logic [W-1:0]  result_o,
    output logic          ovf_o,
    output logic          wr_en_o
);
    logic [W-1:0]  sum;
    logic          sovf;
    logic          is_sub;
    logic          is_trap;
    logic [SW-1:0] sh_amt;
    shift_kind_e   sh_kind;
    logic [W-1:0]  sh_res;
    logic [CW-1:0] clz_cnt, clo_cnt;
    logic [3:0]    cmp_sel;
    logic          cmp_hit;

    always_comb begin
        is_sub  = (op_i == OP_SUBW) || (op_i == OP_SUBT);
        is_trap = (op_i == OP_ADDT) || (op_i == OP_SUBT);
        // variable shifts take the amount from A, immediate ones from shamt_i
        sh_amt  = (op_i >= OP_SLLV) ? a_i[SW-1:0] : shamt_i;
        unique case (op_i)
            OP_SRLI, OP_SRLV: sh_kind = SH_RLOG;
            OP_SRAI, OP_SRAV: sh_kind = SH_RARI;
            default:          sh_kind = SH_LEFT;
        endcase
        cmp_sel = 4'(op_i - 5'(FIRST_CMP));
    end

    alu_addsub #(.W(W)) u_addsub (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (is_sub),
        .sum_o  (sum),
        .sovf_o (sovf)
    );

    alu_shifter #(.W(W)) u_shift (
        .val_i  (b_i),
        .amt_i  (sh_amt),
        .kind_i (sh_kind),
        .res_o  (sh_res)
    );

    alu_lead_count #(.W(W), .ONES(1'b0)) u_clz (
        .val_i (a_i),
        .cnt_o (clz_cnt)
    );

    alu_lead_count #(.W(W), .ONES(1'b1)) u_clo (
        .val_i (a_i),
        .cnt_o (clo_cnt)
    );

    alu_compare #(.W(W)) u_cmp (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (cmp_sel),
        .hit_o (cmp_hit)
    );

    always_comb begin
        unique case (op_i)
            OP_ADDW, OP_ADDT, OP_SUBW, OP_SUBT: result_o = sum;
            OP_AND:  result_o = a_i & b_i;
            OP_OR:   result_o = a_i | b_i;
            OP_XOR:  result_o = a_i ^ b_i;
            OP_NOR:  result_o = ~(a_i | b_i);
            OP_SLLI, OP_SRLI, OP_SRAI,
            OP_SLLV, OP_SRLV, OP_SRAV:          result_o = sh_res;
            OP_CLZ:  result_o = W'(clz_cnt);
            OP_CLO:  result_o = W'(clo_cnt);
            OP_EQ, OP_NE, OP_GES, OP_GEU, OP_LTS, OP_LTU,
            OP_GEZ, OP_GTZ, OP_LEZ, OP_LTZ:     result_o = W'(cmp_hit);
            default: result_o = '0;
        endcase
        ovf_o   = is_trap && sovf;
        wr_en_o = !ovf_o;
    end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic [4:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] result_o,
    input logic         ovf_o,
    input logic         wr_en_o
);
    always_comb begin
        if (!$isunknown({op_i, a_i, b_i, result_o, ovf_o, wr_en_o})) begin
            // R1
            no_overflow_chk: assert (!((op_i == OP_ADDW || op_i == OP_SUBW) && ovf_o));
            // R12
            write_block_chk: assert (wr_en_o != ovf_o);
            // R2
            add_trap_sign_chk: assert (!(op_i == OP_ADDT && ovf_o)
                                       || (a_i[W-1] == b_i[W-1] && result_o[W-1] != a_i[W-1]));
            // R9
            compare_bool_chk: assert (!(op_i >= OP_EQ && op_i <= OP_LTZ) || result_o[W-1:1] == '0);
            // R7
            count_range_chk: assert (!(op_i == OP_CLZ || op_i == OP_CLO) || result_o <= W);
            // R11
            unused_zero_chk: assert (!(op_i > OP_LTZ) || (result_o == '0 && !ovf_o));
        end
    end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_int_alu_chk (
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .ovf_o    (ovf_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/int_alu_bench.sv
`timescale 1ns/1ps
module int_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op = '0;
    logic [31:0] a = '0, b = '0;
    logic [4:0]  sh = '0;
    logic [31:0] res;
    logic        ovf, wen;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    always #2 clk = ~clk;   // 250 MHz

    int_alu u_int_alu (
        .op_i(op), .a_i(a), .b_i(b), .shamt_i(sh),
        .result_o(res), .ovf_o(ovf), .wr_en_o(wen)
    );

    function automatic string req_of(input int o);
        if (o == 0 || o == 2) return "R1";
        if (o == 1) return "R2";
        if (o == 3) return "R3";
        if (o <= 7) return "R4";
        if (o <= 10) return "R5";
        if (o <= 13) return "R6";
        if (o == 14) return "R7";
        if (o == 15) return "R8";
        if (o <= 21) return "R9";
        if (o <= 25) return "R10";
        return "R11";
    endfunction

    function automatic int lead(input logic [31:0] v, input bit bitval);
        int n = 0;
        while (n < 32 && v[31-n] == bitval) n++;
        return n;
    endfunction

    task automatic model(input int o, input logic [31:0] x, input logic [31:0] y,
                         input int s, output logic [31:0] r, output bit f);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint t;
        int     va = int'(x[4:0]);
        f = 0;
        case (o)
            0, 1: begin t = sx + sy; r = x + y; f = (o == 1) && (t > 64'sd2147483647 || t < -64'sd2147483648); end
            2, 3: begin t = sx - sy; r = x - y; f = (o == 3) && (t > 64'sd2147483647 || t < -64'sd2147483648); end
            4:  r = x & y;
            5:  r = x | y;
            6:  r = x ^ y;
            7:  r = ~(x | y);
            8:  r = y << s;
            9:  r = y >> s;
            10: r = $signed(y) >>> s;
            11: r = y << va;
            12: r = y >> va;
            13: r = $signed(y) >>> va;
            14: r = 32'(lead(x, 1'b0));
            15: r = 32'(lead(x, 1'b1));
            16: r = 32'(x == y);
            17: r = 32'(x != y);
            18: r = 32'(sx >= sy);
            19: r = 32'(x >= y);
            20: r = 32'(sx < sy);
            21: r = 32'(x < y);
            22: r = 32'(sx >= 0);
            23: r = 32'(sx > 0);
            24: r = 32'(sx <= 0);
            25: r = 32'(sx < 0);
            default: r = '0;
        endcase
    endtask

    task automatic run(input int o, input logic [31:0] x, input logic [31:0] y, input int s);
        logic [31:0] er;
        bit          ef;
        @(negedge clk);
        op = 5'(o); a = x; b = y; sh = 5'(s);
        model(o, x, y, s, er, ef);
        @(posedge clk);
        #1;
        checks++;
        if (res !== er || ovf !== ef || wen !== !ef) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got res=%h ovf=%b wen=%b, exp res=%h ovf=%b wen=%b (R12 on wen)",
                     req_of(o), o, x, y, s, res, ovf, wen, er, ef, !ef);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // initial state: code 0 with zero operands gives zero, write enabled (R1)
        run(0, 32'h0, 32'h0, 0);
        // R1: wrapping forms never flag
        run(0, 32'h7fffffff, 32'h1, 0);
        run(2, 32'h80000000, 32'h1, 0);
        // R2: add overflow boundaries
        run(1, 32'h7fffffff, 32'h1, 0);
        run(1, 32'h80000000, 32'hffffffff, 0);
        run(1, 32'h7ffffffe, 32'h1, 0);
        run(1, 32'h80000000, 32'h7fffffff, 0);
        // R3: subtract overflow boundaries
        run(3, 32'h80000000, 32'h1, 0);
        run(3, 32'h7fffffff, 32'hffffffff, 0);
        run(3, 32'h0, 32'h80000000, 0);
        run(3, 32'hffffffff, 32'h80000000, 0);
        // R4: NOR of zeros
        run(7, 32'h0, 32'h0, 0);
        // R5 / R6: every amount, sign-bit set value, noisy upper A bits
        for (int s = 0; s < 32; s++) begin
            for (int o = 8; o <= 10; o++) run(o, 32'hdead_bee0, 32'h8421_0f0f, s);
            for (int o = 11; o <= 13; o++) run(o, {27'h5a5a5a5, 5'(s)}, 32'h8421_0f0f, 31 - s);
        end
        // R7 / R8: edges
        run(14, 32'h0, 32'h0, 0);
        run(14, 32'h1, 32'h0, 0);
        run(14, 32'h80000000, 32'h0, 0);
        run(15, 32'hffffffff, 32'h0, 0);
        run(15, 32'h0, 32'h0, 0);
        run(15, 32'hfffffffe, 32'h0, 0);
        for (int k = 0; k < 32; k++) begin
            run(14, 32'h1 << k, 32'h0, 0);
            run(15, ~(32'h1 << k), 32'h0, 0);
        end
        // R9: signed vs unsigned disagreement, equality
        for (int o = 16; o <= 21; o++) begin
            run(o, 32'hffffffff, 32'h1, 0);
            run(o, 32'h1, 32'hffffffff, 0);
            run(o, 32'h1234, 32'h1234, 0);
        end
        // R10: zero tests with noisy B
        for (int o = 22; o <= 25; o++) begin
            run(o, 32'h0, 32'hffffffff, 0);
            run(o, 32'h1, 32'h0, 0);
            run(o, 32'h80000000, 32'h7fffffff, 0);
        end
        // R11: unused codes
        for (int o = 26; o < 32; o++) run(o, 32'h7fffffff, 32'h1, 3);
        // random sweep across all codes
        for (int i = 0; i < 6000; i++)
            run(i % 32, $urandom, $urandom, int'($urandom % 32));
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule